// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the processor-facing programming port of a four-channel DMA controller. A host reaches it through an active-low select, a 4-bit register address, active-low read and write strobes and an 8-bit data path. Inside it keeps the per-channel 16-bit base and current address and word-count registers, plus the command, per-channel mode, software request, mask, status and temporary registers. A single byte-pointer bit decides whether an access to a 16-bit register moves its low or its high byte.

The transfer engine and the arbiter sit outside. They read the register contents from flat output buses. They push terminal-count events, live request levels, temporary data and updated current address and count values back in through dedicated inputs. Each strobe is treated as one access. A write takes effect on the first clock edge that sees the strobe active. The side effects of a read take effect on the first edge after the read strobe is released.

Top module: `dma_reg_port`

## Requirements
- R1: While `rst` is high, and after it falls, the command, software request, status and temporary registers read zero, every mask bit is 1, the byte pointer is 0 and the mode read-back counter is 0.
- R2: While `csN` is high, a strobe has no effect. No register changes, the byte pointer does not move and `dataOe` stays 0.
- R3: Addresses 0 to 7 select channel `addr[2:1]`. `addr[0]`=0 is the address register and 1 is the count register. An access moves the low byte when the pointer is 0 and the high byte when it is 1. Every such read or write then toggles the pointer, which all channels share.
- R4: A write to a base register loads the same byte of the matching current register. The other byte of the current register is left alone. Reads of addresses 0 to 7 return the current register. A pulse on `engUpd[c]` loads `engAddr` and `engCnt` into the current registers of channel c.
- R5: A write to address 12 clears the byte pointer and changes nothing else.
- R6: A read of address 8 returns `{reqIn[3:0], tc[3:0]}`. A pulse on `tcIn[c]` sets the sticky flag tc[c]. The end of a status read clears all tc flags, but a `tcIn` pulse in that same cycle still sets its flag.
- R7: A write to address 10 sets mask bit `data[1:0]` to `data[2]`. A write to address 15 loads all four mask bits from `data[3:0]`.
- R8: A write to address 9 sets software request bit `data[1:0]` to `data[2]`.
- R9: A write to address 11 stores `data[7:2]` as the mode of channel `data[1:0]`. Each read of address 11 returns `{mode[k], k}` with k the mode counter. The counter then increments modulo 4.
- R10: A write to address 8 loads the command register. A read of address 13 returns the temporary register, which `tempLd` loads from `tempIn`.
- R11: `dataOe` is 1 exactly while `csN` and `rdN` are low and `wrN` is high. `dataOut` is 0 whenever `dataOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| csN | input | 1 | Active-low select |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| addr | input | 4 | Register address |
| dataIn | input | 8 | Write data from host |
| dataOut | output | 8 | Read data to host |
| dataOe | output | 1 | Read data valid / bus drive enable |
| tcIn | input | 4 | Terminal-count event pulses per channel |
| reqIn | input | 4 | Live request levels per channel |
| engUpd | input | 4 | Per-channel current-register update strobe |
| engAddr | input | 16 | New current address from engine |
| engCnt | input | 16 | New current count from engine |
| tempLd | input | 1 | Temporary register load strobe |
| tempIn | input | 8 | Temporary register data |
| cmdOut | output | 8 | Command register |
| maskOut | output | 4 | Mask bits |
| reqOut | output | 4 | Software request bits |
| modeOut | output | 24 | Mode registers, channel c at [6c+5:6c] |
| baseAddrOut | output | 64 | Base addresses, channel c at [16c+15:16c] |
| baseCntOut | output | 64 | Base counts |
| curAddrOut | output | 64 | Current addresses |
| curCntOut | output | 64 | Current counts |

## Verification
The hardest state to reach is one where the byte pointer and the register contents disagree with a naive model. Two cases produce it. In the first, a 16-bit read follows a write to a different register, so the read lands on the high byte. In the second, the engine has rewritten a current register and a base write must replace only one of its bytes. The stimulus builds both cases on purpose. It writes a single low byte, reads back through the shared pointer, injects an engine update, then clears the pointer and writes one byte. A terminal-count pulse is also placed in the very cycle a status read ends, to show the set beats the clear.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;
  localparam int NCH    = 4;
  localparam int CH_W   = $clog2(NCH);
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int MODE_W = BYTE_W - CH_W;
  localparam int ADDR_W = 4;

  localparam logic [2:0] SUB_STATCMD = 3'd0;
  localparam logic [2:0] SUB_REQ     = 3'd1;
  localparam logic [2:0] SUB_MASK1   = 3'd2;
  localparam logic [2:0] SUB_MODE    = 3'd3;
  localparam logic [2:0] SUB_CLRPTR  = 3'd4;
  localparam logic [2:0] SUB_TEMP    = 3'd5;
  localparam logic [2:0] SUB_MASKALL = 3'd7;

  typedef enum logic [2:0] {
    RD_NONE, RD_ADDR, RD_CNT, RD_STATUS, RD_MODE, RD_TEMP
  } rdKind_e;

  typedef struct packed {
    logic            wrWord;
    logic            wrIsCnt;
    logic [CH_W-1:0] chan;
    logic            hiByte;
    logic            wrCmd;
    logic            wrReq;
    logic            wrMask1;
    logic            wrMaskAll;
    logic            wrMode;
    logic            clrTc;
    rdKind_e         rdKind;
    logic [CH_W-1:0] rdChan;
  } ctlStrobes_t;
endpackage

// File: rtl/dma_reg_ctrl.sv
module dma_reg_ctrl
  import dma_reg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 csN,
  input  logic                 rdN,
  input  logic                 wrN,
  input  logic [ADDR_W-1:0]    addr,
  output ctlStrobes_t          stb,
  output logic                 dataOe
);
  logic wrAct, rdAct, wrActQ, rdActQ, wrStart, rdEnd;
  logic bytePtr;
  logic [CH_W-1:0] modeCnt;
  rdKind_e curKind, heldKind;
  logic isWord;
  logic [2:0] sub;

  assign wrAct   = !csN && !wrN;
  assign rdAct   = !csN && !rdN && wrN;
  assign wrStart = wrAct && !wrActQ;
  assign rdEnd   = rdActQ && !rdAct;
  assign isWord  = !addr[ADDR_W-1];
  assign sub     = addr[2:0];
  assign dataOe  = rdAct;

  always_comb begin
    curKind = RD_NONE;
    if (isWord) curKind = addr[0] ? RD_CNT : RD_ADDR;
    else begin
      case (sub)
        SUB_STATCMD: curKind = RD_STATUS;
        SUB_MODE:    curKind = RD_MODE;
        SUB_TEMP:    curKind = RD_TEMP;
        default:     curKind = RD_NONE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.chan      = addr[CH_W:1];
    stb.hiByte    = bytePtr;
    stb.wrIsCnt   = addr[0];
    stb.wrWord    = wrStart && isWord;
    stb.wrCmd     = wrStart && !isWord && (sub == SUB_STATCMD);
    stb.wrReq     = wrStart && !isWord && (sub == SUB_REQ);
    stb.wrMask1   = wrStart && !isWord && (sub == SUB_MASK1);
    stb.wrMaskAll = wrStart && !isWord && (sub == SUB_MASKALL);
    stb.wrMode    = wrStart && !isWord && (sub == SUB_MODE);
    stb.clrTc     = rdEnd && (heldKind == RD_STATUS);
    stb.rdKind    = rdAct ? curKind : RD_NONE;
    stb.rdChan    = (curKind == RD_MODE) ? modeCnt : addr[CH_W:1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrActQ   <= 1'b0;
      rdActQ   <= 1'b0;
      bytePtr  <= 1'b0;
      modeCnt  <= '0;
      heldKind <= RD_NONE;
    end else begin
      wrActQ <= wrAct;
      rdActQ <= rdAct;
      if (rdAct) heldKind <= curKind;
      if (wrStart && !isWord && (sub == SUB_CLRPTR))
        bytePtr <= 1'b0;
      else if (stb.wrWord || (rdEnd && (heldKind == RD_ADDR || heldKind == RD_CNT)))
        bytePtr <= !bytePtr;
      if (rdEnd && heldKind == RD_MODE)
        modeCnt <= modeCnt + 1'b1;
    end
  end
endmodule

// File: rtl/dma_reg_dpath.sv
module dma_reg_dpath
  import dma_reg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  ctlStrobes_t              stb,
  input  logic [BYTE_W-1:0]        dataIn,
  input  logic [NCH-1:0]           tcIn,
  input  logic [NCH-1:0]           reqIn,
  input  logic [NCH-1:0]           engUpd,
  input  logic [WORD_W-1:0]        engAddr,
  input  logic [WORD_W-1:0]        engCnt,
  input  logic                     tempLd,
  input  logic [BYTE_W-1:0]        tempIn,
  output logic [BYTE_W-1:0]        rdData,
  output logic [BYTE_W-1:0]        cmdOut,
  output logic [NCH-1:0]           maskOut,
  output logic [NCH-1:0]           reqOut,
  output logic [NCH*MODE_W-1:0]    modeOut,
  output logic [NCH*WORD_W-1:0]    baseAddrOut,
  output logic [NCH*WORD_W-1:0]    baseCntOut,
  output logic [NCH*WORD_W-1:0]    curAddrOut,
  output logic [NCH*WORD_W-1:0]    curCntOut
);
  logic [NCH-1:0][WORD_W-1:0] baseAddr, baseCnt, curAddr, curCnt;
  logic [NCH-1:0][MODE_W-1:0] modeReg;
  logic [NCH-1:0] maskReg, reqReg, tcFlags;
  logic [BYTE_W-1:0] cmdReg, tempReg;
  logic [CH_W-1:0] selCh;

  assign selCh = dataIn[CH_W-1:0];

  function automatic logic [WORD_W-1:0] putByte(input logic [WORD_W-1:0] old,
                                                input logic hi,
                                                input logic [BYTE_W-1:0] b);
    return hi ? {b, old[BYTE_W-1:0]} : {old[WORD_W-1:BYTE_W], b};
  endfunction

  function automatic logic [BYTE_W-1:0] getByte(input logic [WORD_W-1:0] w,
                                                input logic hi);
    return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      baseAddr <= '0;
      baseCnt  <= '0;
      curAddr  <= '0;
      curCnt   <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (engUpd[c]) begin
          curAddr[c] <= engAddr;
          curCnt[c]  <= engCnt;
        end
        if (stb.wrWord && stb.chan == CH_W'(c)) begin
          if (stb.wrIsCnt) begin
            baseCnt[c] <= putByte(baseCnt[c], stb.hiByte, dataIn);
            curCnt[c]  <= putByte(engUpd[c] ? engCnt : curCnt[c], stb.hiByte, dataIn);
          end else begin
            baseAddr[c] <= putByte(baseAddr[c], stb.hiByte, dataIn);
            curAddr[c]  <= putByte(engUpd[c] ? engAddr : curAddr[c], stb.hiByte, dataIn);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdReg  <= '0;
      tempReg <= '0;
      tcFlags <= '0;
      reqReg  <= '0;
      maskReg <= '1;
      modeReg <= '0;
    end else begin
      if (stb.wrCmd) cmdReg <= dataIn;
      if (tempLd) tempReg <= tempIn;
      tcFlags <= (stb.clrTc ? '0 : tcFlags) | tcIn;
      if (stb.wrReq) reqReg[selCh] <= dataIn[2];
      if (stb.wrMask1) maskReg[selCh] <= dataIn[2];
      else if (stb.wrMaskAll) maskReg <= dataIn[NCH-1:0];
      if (stb.wrMode) modeReg[selCh] <= dataIn[BYTE_W-1:CH_W];
    end
  end

  always_comb begin
    case (stb.rdKind)
      RD_ADDR:   rdData = getByte(curAddr[stb.rdChan], stb.hiByte);
      RD_CNT:    rdData = getByte(curCnt[stb.rdChan], stb.hiByte);
      RD_STATUS: rdData = {reqIn, tcFlags};
      RD_MODE:   rdData = {modeReg[stb.rdChan], stb.rdChan};
      RD_TEMP:   rdData = tempReg;
      default:   rdData = '0;
    endcase
  end

  assign cmdOut  = cmdReg;
  assign maskOut = maskReg;
  assign reqOut  = reqReg;

  for (genvar c = 0; c < NCH; c++) begin : g_flat
    assign modeOut[c*MODE_W +: MODE_W]     = modeReg[c];
    assign baseAddrOut[c*WORD_W +: WORD_W] = baseAddr[c];
    assign baseCntOut[c*WORD_W +: WORD_W]  = baseCnt[c];
    assign curAddrOut[c*WORD_W +: WORD_W]  = curAddr[c];
    assign curCntOut[c*WORD_W +: WORD_W]   = curCnt[c];
  end
endmodule

// File: rtl/dma_reg_port.sv
module dma_reg_port
  import dma_reg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  csN,
  input  logic                  rdN,
  input  logic                  wrN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BYTE_W-1:0]     dataIn,
  output logic [BYTE_W-1:0]     dataOut,
  output logic                  dataOe,
  input  logic [NCH-1:0]        tcIn,
  input  logic [NCH-1:0]        reqIn,
  input  logic [NCH-1:0]        engUpd,
  input  logic [WORD_W-1:0]     engAddr,
  input  logic [WORD_W-1:0]     engCnt,
  input  logic                  tempLd,
  input  logic [BYTE_W-1:0]     tempIn,
  output logic [BYTE_W-1:0]     cmdOut,
  output logic [NCH-1:0]        maskOut,
  output logic [NCH-1:0]        reqOut,
  output logic [NCH*MODE_W-1:0] modeOut,
  output logic [NCH*WORD_W-1:0] baseAddrOut,
  output logic [NCH*WORD_W-1:0] baseCntOut,
  output logic [NCH*WORD_W-1:0] curAddrOut,
  output logic [NCH*WORD_W-1:0] curCntOut
);
  ctlStrobes_t stb;
  logic [BYTE_W-1:0] rdData;
  logic oeInt;

  dma_reg_ctrl u_ctrl (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addr(addr), .stb(stb), .dataOe(oeInt)
  );

  dma_reg_dpath u_dpath (
    .clk(clk), .rst(rst), .stb(stb), .dataIn(dataIn),
    .tcIn(tcIn), .reqIn(reqIn), .engUpd(engUpd),
    .engAddr(engAddr), .engCnt(engCnt),
    .tempLd(tempLd), .tempIn(tempIn), .rdData(rdData),
    .cmdOut(cmdOut), .maskOut(maskOut), .reqOut(reqOut),
    .modeOut(modeOut), .baseAddrOut(baseAddrOut), .baseCntOut(baseCntOut),
    .curAddrOut(curAddrOut), .curCntOut(curCntOut)
  );

  assign dataOe  = oeInt;
  assign dataOut = oeInt ? rdData : '0;
endmodule

// File: rtl/dma_reg_port_chk.sv
module dma_reg_port_chk
  import dma_reg_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  csN,
  input logic                  rdN,
  input logic                  wrN,
  input logic                  dataOe,
  input logic [BYTE_W-1:0]     dataOut,
  input logic [BYTE_W-1:0]     cmdOut,
  input logic [NCH-1:0]        maskOut,
  input logic [NCH-1:0]        reqOut,
  input logic [NCH*MODE_W-1:0] modeOut
);
  // R1: registers leave reset in their defined state
  p_reset_state_r1: assert property (@(posedge clk)
    $fell(rst) |-> (maskOut == '1 && reqOut == '0 && cmdOut == '0));

  // R2: deselected port never drives the bus
  p_cs_no_drive_r2: assert property (@(posedge clk) disable iff (rst)
    csN |-> !dataOe);

  // R2: deselected cycle leaves programmed registers unchanged
  p_cs_no_change_r2: assert property (@(posedge clk) disable iff (rst)
    (csN && !rst) |=> ($stable(cmdOut) && $stable(maskOut) && $stable(reqOut) && $stable(modeOut)));

  // R11: output enable only inside a read strobe
  p_oe_in_read_r11: assert property (@(posedge clk) disable iff (rst)
    dataOe |-> (!rdN && wrN));

  // R11: bus value is zero while not enabled
  p_quiet_bus_r11: assert property (@(posedge clk) disable iff (rst)
    !dataOe |-> (dataOut == '0));
endmodule

bind dma_reg_port dma_reg_port_chk u_chk (
  .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN),
  .dataOe(dataOe), .dataOut(dataOut), .cmdOut(cmdOut),
  .maskOut(maskOut), .reqOut(reqOut), .modeOut(modeOut)
);

// File: tb/test_dma_reg_port.sv
module test_dma_reg_port;
  logic clk = 0, rst = 1, csN = 1, rdN = 1, wrN = 1;
  logic [3:0] addr = 0;
  logic [7:0] dataIn = 0, dataOut, tempIn = 0;
  logic dataOe, tempLd = 0;
  logic [3:0] tcIn = 0, reqIn = 0, engUpd = 0, maskOut, reqOut;
  logic [15:0] engAddr = 0, engCnt = 0;
  logic [7:0] cmdOut;
  logic [23:0] modeOut;
  logic [63:0] baseAddrOut, baseCntOut, curAddrOut, curCntOut;
  int total = 0, bad = 0;
  logic [7:0] rv;
  logic oe;

  always #4 clk = ~clk;

  dma_reg_port i_dma_reg_port (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .tcIn(tcIn),
    .reqIn(reqIn), .engUpd(engUpd), .engAddr(engAddr), .engCnt(engCnt),
    .tempLd(tempLd), .tempIn(tempIn), .cmdOut(cmdOut), .maskOut(maskOut),
    .reqOut(reqOut), .modeOut(modeOut), .baseAddrOut(baseAddrOut),
    .baseCntOut(baseCntOut), .curAddrOut(curAddrOut), .curCntOut(curCntOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic sel = 1);
    @(negedge clk);
    csN = !sel; addr = a; dataIn = d; wrN = 0;
    @(negedge clk);
    wrN = 1; csN = 1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input logic sel = 1);
    @(negedge clk);
    csN = !sel; addr = a; rdN = 0;
    #1; rv = dataOut; oe = dataOe;
    @(negedge clk);
    rdN = 1; csN = 1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    wr(4'd8, 8'h5A); wr(4'd15, 4'h0); wr(4'd9, 8'h05); wr(4'd0, 8'h77);
    tempIn = 8'h99; tempLd = 1; @(negedge clk); tempLd = 0;
    rd(4'd11);
    do_reset();
    check("R1 cmd", cmdOut, 8'h00);
    check("R1 mask", maskOut, 4'hF);
    check("R1 req", reqOut, 4'h0);
    rd(4'd8);  check("R1 status", rv, 8'h00);
    rd(4'd13); check("R1 temp", rv, 8'h00);
    wr(4'd2, 8'h3C); check("R1 pointer low byte", curAddrOut[31:16], 16'h003C);
    rd(4'd11); check("R1 mode counter", rv[1:0], 2'd0);
  endtask

  task automatic t_cs_ignore();
    do_reset();
    wr(4'd15, 8'h00, 0);   check("R2 mask unchanged", maskOut, 4'hF);
    wr(4'd8, 8'hFF, 0);    check("R2 cmd unchanged", cmdOut, 8'h00);
    wr(4'd0, 8'hAB, 0);    check("R2 addr unchanged", curAddrOut[15:0], 16'h0000);
    rd(4'd13, 0);          check("R2 no drive", {oe, rv}, 9'h000);
    wr(4'd0, 8'h21);       check("R2 pointer not moved", curAddrOut[15:0], 16'h0021);
  endtask

  task automatic t_word_seq();
    do_reset();
    wr(4'd0, 8'h34); wr(4'd0, 8'h12);
    check("R3 addr ch0", curAddrOut[15:0], 16'h1234);
    rd(4'd0); check("R3 read lo", rv, 8'h34);
    rd(4'd0); check("R3 read hi", rv, 8'h12);
    wr(4'd7, 8'hCD); wr(4'd7, 8'hAB);
    check("R3 cnt ch3", curCntOut[63:48], 16'hABCD);
    wr(4'd2, 8'h55);
    rd(4'd2); check("R3 shared pointer reads hi", rv, 8'h00);
    rd(4'd7); check("R3 after toggle reads lo", rv, 8'hCD);
  endtask

  task automatic t_base_current();
    do_reset();
    wr(4'd5, 8'h10); wr(4'd5, 8'h20);
    check("R4 base cnt ch2", baseCntOut[47:32], 16'h2010);
    check("R4 cur cnt ch2", curCntOut[47:32], 16'h2010);
    @(negedge clk); engUpd = 4'b0100; engAddr = 16'hFFFF; engCnt = 16'h0F0F;
    @(negedge clk); engUpd = 0;
    check("R4 engine cur addr", curAddrOut[47:32], 16'hFFFF);
    check("R4 base kept", baseCntOut[47:32], 16'h2010);
    wr(4'd4, 8'h11);
    check("R4 one byte of current", curAddrOut[47:32], 16'hFF11);
    check("R4 base lo", baseAddrOut[47:32], 16'h0011);
    rd(4'd5); check("R4 read current", rv, 8'h0F);
  endtask

  task automatic t_clr_ptr();
    do_reset();
    wr(4'd8, 8'h3E);
    wr(4'd6, 8'hAA);
    wr(4'd12, 8'h00);
    check("R5 cmd untouched", cmdOut, 8'h3E);
    wr(4'd6, 8'hBB);
    check("R5 back to low byte", curAddrOut[63:48], 16'h00BB);
    check("R10 cmd write", cmdOut, 8'h3E);
  endtask

  task automatic t_status();
    do_reset();
    reqIn = 4'b1000;
    @(negedge clk); tcIn = 4'b0010; @(negedge clk); tcIn = 0;
    rd(4'd8); check("R6 status sticky", rv, 8'h82);
    rd(4'd8); check("R6 cleared by read", rv, 8'h80);
    @(negedge clk); tcIn = 4'b0001; @(negedge clk); tcIn = 0;
    @(negedge clk); csN = 0; addr = 4'd8; rdN = 0;
    @(negedge clk); rdN = 1; csN = 1; tcIn = 4'b0100;
    @(negedge clk); tcIn = 0;
    rd(4'd8); check("R6 set beats clear", rv, 8'h84);
    reqIn = 0;
  endtask

  task automatic t_mask_req();
    do_reset();
    wr(4'd15, 8'h05); check("R7 all masks", maskOut, 4'h5);
    wr(4'd10, 8'h06); check("R7 set bit2", maskOut, 4'h5);
    wr(4'd10, 8'h02); check("R7 clear bit2", maskOut, 4'h1);
    wr(4'd10, 8'h07); check("R7 set bit3", maskOut, 4'h9);
    wr(4'd9, 8'h05);  check("R8 set req1", reqOut, 4'h2);
    wr(4'd9, 8'h07);  check("R8 set req3", reqOut, 4'hA);
    wr(4'd9, 8'h01);  check("R8 clear req1", reqOut, 4'h8);
  endtask

  task automatic t_mode();
    do_reset();
    for (int c = 0; c < 4; c++) wr(4'd11, {6'(c * 9 + 3), 2'(c)});
    check("R9 mode ch2", modeOut[17:12], 6'd21);
    for (int c = 0; c < 4; c++) begin
      rd(4'd11); check("R9 mode readback", rv, {6'(c * 9 + 3), 2'(c)});
    end
    rd(4'd11); check("R9 counter wraps", rv, {6'd3, 2'd0});
    do_reset();
    rd(4'd11); check("R9 counter reset", rv[1:0], 2'd0);
  endtask

  task automatic t_temp_oe();
    do_reset();
    @(negedge clk); tempIn = 8'hC3; tempLd = 1; @(negedge clk); tempLd = 0;
    rd(4'd13); check("R10 temp read", rv, 8'hC3);
    check("R11 oe during read", oe, 1'b1);
    @(negedge clk); csN = 0; rdN = 0; wrN = 0; addr = 4'd13;
    #1; check("R11 no oe with write", {dataOe, dataOut}, 9'h000);
    @(negedge clk); csN = 1; rdN = 1; wrN = 1;
    @(negedge clk);
    check("R11 idle no oe", dataOe, 1'b0);
  endtask

  initial begin
    #1600000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_cs_ignore();
    t_word_seq();
    t_base_current();
    t_clr_ptr();
    t_status();
    t_mask_req();
    t_mode();
    t_temp_oe();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule